// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block gathers interrupt requests for one processor. A bank of internal level sources is sampled into a status word. A programmable mask word qualifies that status word. When any qualified bit is set, one combined internal request line is raised. A round-robin encoder names the internal source to service next. Its search starts one position after the source that was last acknowledged and wraps around at the top of the bank. Acknowledging a grant records its index as the new rotation point and clears that source's mask bit. The source stays silent until software enables it again.

A small group of external pins each drive a request line of their own. Every pin passes through a two-stage synchroniser. Each pin has its own configuration: enable, level or edge detection, active polarity, an any-transition option, and a write-one clear for the captured edge. A priority code summarises the highest active request. The order is the timer line, then the combined internal line, then the external lines from lowest index upward.

Top module: `irqc_top`

## Requirements
- R1: After reset, the mask word and all external configuration bits are 0. Every request output and the priority code are 0, grant_vld is 0, and the first round-robin search starts at index 0.
- R2: Register map by `addr`: 0 returns the status word, which is read-only and holds the source levels sampled on the previous clock edge. 1 is the mask word, readable and writable. 2 is the external configuration word. 3 reads as 0.
- R3: `int_irq` is high exactly when the status word AND the mask word is nonzero.
- R4: `grant_idx` is the first index with a pending bit (status AND mask), searching upward from the last acknowledged index plus one and wrapping from 31 to 0. `grant_vld` is high when any bit is pending.
- R5: A cycle with `grant_ack` high while `grant_vld` is high stores `grant_idx` as the last acknowledged index and clears its mask bit. This clear is applied after any mask write in the same cycle.
- R6: External configuration word layout for pin i: bit i is the clear/captured-state bit, bit 4+i is enable, bit 8+i is any-transition, bit 12+i selects level mode, and bit 16+i is the polarity (1 = active high). All other bits read as 0.
- R7: In edge mode, an edge into the active polarity sets a sticky capture bit. It holds until a write of 1 to the clear bit. A new edge in the same cycle wins over the clear. An edge out of the active polarity does nothing.
- R8: With any-transition set in edge mode, both rising and falling pin edges set the capture bit, whatever the polarity.
- R9: In level mode, the pending state follows the pin after polarity is applied, and a write to the clear bit has no effect.
- R10: The enable bit gates only the request line `ext_irq[i]`. The captured state stays visible at bit i of the configuration word while enable is 0.
- R11: `svc_sel` gives 1 for the timer, 2 for the internal line, and 3+i for external line i, with that order of precedence. It gives 0 when nothing is active.
- R12: In level mode a pin change reaches `ext_irq` on the second clock edge after it, and not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lvl | input | 32 | Internal source levels |
| timer_irq | input | 1 | Timer request, for the priority code only |
| ext_pin | input | 4 | Asynchronous external request pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| grant_ack | input | 1 | Acknowledge the current grant |
| grant_idx | output | 5 | Internal source selected by rotation |
| grant_vld | output | 1 | Some internal source is pending |
| int_irq | output | 1 | Combined internal request |
| ext_irq | output | 4 | Per-pin external requests |
| svc_sel | output | 3 | Highest active request code |

## Verification
The bench acknowledges a grant and then re-enables every mask bit. A design with fixed priority would grant the lowest index again; the rotating design moves on past the last acknowledged index. A later acknowledge at index 31 checks the wrap back to 0, which a pointer without modulo would miss. Polarity, any-transition and level mode are each driven against the edge that should be ignored. The clear bit is written in level mode, and a pin is captured while its enable is off. These cases catch a latch that ignores polarity, a clear that disturbs level sources, or an enable that gates the capture. The level-mode latency is sampled on both sides of the second edge, so a missing or extra synchroniser stage is caught.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_STATUS = 0;
  localparam int REG_MASK   = 1;
  localparam int REG_EXT    = 2;

  localparam int FLD_CLR   = 0;
  localparam int FLD_EN    = 1;
  localparam int FLD_BOTH  = 2;
  localparam int FLD_LVL   = 3;
  localparam int FLD_SENSE = 4;
  localparam int FLD_COUNT = 5;

  localparam int SEL_NONE  = 0;
  localparam int SEL_TIMER = 1;
  localparam int SEL_INT   = 2;
  localparam int SEL_EXT0  = 3;

  // bit position of a per-pin field in the external configuration word
  function automatic int ext_pos(int fld, int line, int n_ext);
    return fld * n_ext + line;
  endfunction
endpackage

// File: rtl/irqc_ext_line.sv
module irqc_ext_line (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic clr,
  input  logic en,
  input  logic both,
  input  logic lvl,
  input  logic sense,
  output logic pend,
  output logic line
);
  // sh[0], sh[1]: synchroniser; sh[2]: previous synchronised value
  logic [2:0] sh;
  logic       latch_q;
  logic       q_now, q_prev, edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], pin};
  end

  // polarity applied to both samples with the current sense, so a sense
  // change alone never creates an edge
  assign q_now    = sense ? sh[1] : ~sh[1];
  assign q_prev   = sense ? sh[2] : ~sh[2];
  assign edge_hit = both ? (sh[1] ^ sh[2]) : (q_now & ~q_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   latch_q <= 1'b0;
    else if (lvl) latch_q <= 1'b0;
    else          latch_q <= edge_hit | (latch_q & ~clr);
  end

  assign pend = lvl ? q_now : latch_q;
  assign line = pend & en;

  a_r7_capture_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && latch_q && !clr) |=> latch_q);
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && clr && !edge_hit) |=> !latch_q);
  a_r10_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !line);
endmodule

// File: rtl/irqc_rr_pick.sv
module irqc_rr_pick #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] idx,
  output logic          vld
);
  // returns {found, index}; scan starts one past 'from' and wraps
  function automatic logic [IW:0] pick(logic [N-1:0] p, logic [IW-1:0] from);
    logic [IW:0] r;
    r = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(from) + k) % N;
      if (!r[IW] && p[j]) r = {1'b1, IW'(j)};
    end
    return r;
  endfunction

  logic [IW:0] res;
  assign res = pick(pend, last);
  assign idx = res[IW-1:0];
  assign vld = res[IW];
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int N_INT = 32,
  parameter int N_EXT = 4,
  parameter int DW    = 32,
  parameter int AW    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_INT-1:0]           src_lvl,
  input  logic                       timer_irq,
  input  logic [N_EXT-1:0]           ext_pin,
  input  logic                       wr_en,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  input  logic                       grant_ack,
  output logic [$clog2(N_INT)-1:0]   grant_idx,
  output logic                       grant_vld,
  output logic                       int_irq,
  output logic [N_EXT-1:0]           ext_irq,
  output logic [$clog2(N_EXT+3)-1:0] svc_sel
);
  import irqc_pkg::*;

  localparam int IW = $clog2(N_INT);
  localparam int SW = $clog2(N_EXT + 3);

  logic [N_INT-1:0] status_q, mask_q, mask_d, pending;
  logic [IW-1:0]    last_q;
  logic [N_EXT-1:0] en_q, both_q, lvl_q, sense_q;
  logic [N_EXT-1:0] clr_pulse, ext_pend;
  logic             wr_mask, wr_ext, ack_fire;
  logic [DW-1:0]    ext_word;

  assign wr_mask  = wr_en && (addr == AW'(REG_MASK));
  assign wr_ext   = wr_en && (addr == AW'(REG_EXT));
  assign ack_fire = grant_ack && grant_vld;

  // status sampling and mask with automatic clear on acknowledge
  always_comb begin
    mask_d = mask_q;
    if (wr_mask)  mask_d = wdata[N_INT-1:0];
    if (ack_fire) mask_d[grant_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      last_q   <= IW'(N_INT - 1);
    end else begin
      status_q <= src_lvl;
      mask_q   <= mask_d;
      if (ack_fire) last_q <= grant_idx;
    end
  end

  assign pending = status_q & mask_q;
  assign int_irq = |pending;

  irqc_rr_pick #(.N(N_INT), .IW(IW)) u_pick (
    .pend (pending),
    .last (last_q),
    .idx  (grant_idx),
    .vld  (grant_vld)
  );

  // external configuration and per-pin detectors
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; both_q <= '0; lvl_q <= '0; sense_q <= '0;
    end else if (wr_ext) begin
      for (int i = 0; i < N_EXT; i++) begin
        en_q[i]    <= wdata[ext_pos(FLD_EN,    i, N_EXT)];
        both_q[i]  <= wdata[ext_pos(FLD_BOTH,  i, N_EXT)];
        lvl_q[i]   <= wdata[ext_pos(FLD_LVL,   i, N_EXT)];
        sense_q[i] <= wdata[ext_pos(FLD_SENSE, i, N_EXT)];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_EXT; i++)
      clr_pulse[i] = wr_ext && wdata[ext_pos(FLD_CLR, i, N_EXT)];
  end

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    irqc_ext_line u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_pin[g]),
      .clr   (clr_pulse[g]),
      .en    (en_q[g]),
      .both  (both_q[g]),
      .lvl   (lvl_q[g]),
      .sense (sense_q[g]),
      .pend  (ext_pend[g]),
      .line  (ext_irq[g])
    );
  end

  // read path
  always_comb begin
    ext_word = '0;
    for (int i = 0; i < N_EXT; i++) begin
      ext_word[ext_pos(FLD_CLR,   i, N_EXT)] = ext_pend[i];
      ext_word[ext_pos(FLD_EN,    i, N_EXT)] = en_q[i];
      ext_word[ext_pos(FLD_BOTH,  i, N_EXT)] = both_q[i];
      ext_word[ext_pos(FLD_LVL,   i, N_EXT)] = lvl_q[i];
      ext_word[ext_pos(FLD_SENSE, i, N_EXT)] = sense_q[i];
    end
  end

  always_comb begin
    case (addr)
      AW'(REG_STATUS): rdata = DW'(status_q);
      AW'(REG_MASK):   rdata = DW'(mask_q);
      AW'(REG_EXT):    rdata = ext_word;
      default:         rdata = '0;
    endcase
  end

  // priority code: timer, internal, then external lines lowest first
  always_comb begin
    svc_sel = SW'(SEL_NONE);
    if (timer_irq)    svc_sel = SW'(SEL_TIMER);
    else if (int_irq) svc_sel = SW'(SEL_INT);
    else begin
      for (int i = N_EXT - 1; i >= 0; i--)
        if (ext_irq[i]) svc_sel = SW'(SEL_EXT0 + i);
    end
  end

  a_r4_grant_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> pending[grant_idx]);
  a_r3_line_has_grant: assert property (@(posedge clk) disable iff (!rst_n)
    int_irq |-> grant_vld);
  a_r5_ack_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !mask_q[$past(grant_idx)]);
  a_r4_pointer_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (last_q == $past(grant_idx)));
  a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mask && !ack_fire) |=> $stable(mask_q));
  a_r11_timer_first: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |-> (svc_sel == SW'(SEL_TIMER)));
endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic        timer_irq = 1'b0;
  logic [3:0]  ext_pin = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        grant_ack = 1'b0;
  logic [4:0]  grant_idx;
  logic        grant_vld;
  logic        int_irq;
  logic [3:0]  ext_irq;
  logic [2:0]  svc_sel;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .timer_irq(timer_irq),
    .ext_pin(ext_pin), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .grant_ack(grant_ack), .grant_idx(grant_idx),
    .grant_vld(grant_vld), .int_irq(int_irq), .ext_irq(ext_irq),
    .svc_sel(svc_sel)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ack();
    grant_ack = 1'b1;
    step();
    grant_ack = 1'b0;
  endtask

  task automatic do_reset();
    ext_pin = '0; src_lvl = '0; timer_irq = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(2'd1, d); check("R1 mask", d, 0);
    rd(2'd2, d); check("R1 ext cfg", d, 0);
    check("R1 outputs", {int_irq, ext_irq, grant_vld, svc_sel}, 0);
    rd(2'd3, d); check("R2 unused addr", d, 0);
  endtask

  task automatic t_status_mask();
    logic [31:0] d;
    do_reset();
    src_lvl = 32'h8000_0101;
    step();
    rd(2'd0, d); check("R2 status", d, 32'h8000_0101);
    check("R3 masked off", int_irq, 0);
    wr(2'd1, 32'h0000_0100);
    rd(2'd1, d); check("R2 mask rw", d, 32'h0000_0100);
    check("R3 line on", int_irq, 1);
    wr(2'd1, 32'h0000_0002);
    check("R3 line off", int_irq, 0);
  endtask

  task automatic t_rotate();
    logic [31:0] d;
    do_reset();
    src_lvl = (32'h1 << 3) | (32'h1 << 10) | (32'h1 << 31);
    wr(2'd1, 32'hFFFF_FFFF);
    check("R4 first from 0", {grant_vld, grant_idx}, {1'b1, 5'd3});
    ack();
    rd(2'd1, d); check("R5 mask cleared", d, 32'hFFFF_FFF7);
    check("R4 next", grant_idx, 10);
    wr(2'd1, 32'hFFFF_FFFF);
    check("R4 rotates past last", grant_idx, 10);
    ack();
    check("R4 after 10", grant_idx, 31);
    ack();
    check("R4 wrap to 0", {grant_vld, grant_idx}, {1'b1, 5'd3});
    ack();
    check("R5 all acked", {grant_vld, int_irq}, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    do_reset();
    wr(2'd2, 32'h0001_0010);          // pin0 edge, active high, enabled
    ext_pin[0] = 1'b1; step(4);
    check("R7 rise captured", ext_irq[0], 1);
    ext_pin[0] = 1'b0; step(4);
    check("R7 sticky", ext_irq[0], 1);
    rd(2'd2, d); check("R6 captured bit", d[0], 1);
    wr(2'd2, 32'h0001_0011);
    check("R7 clear", ext_irq[0], 0);
    wr(2'd2, 32'h0000_0020);          // pin1 edge, active low, enabled
    ext_pin[1] = 1'b1; step(4);
    check("R7 wrong-way edge ignored", ext_irq[1], 0);
    ext_pin[1] = 1'b0; step(4);
    check("R7 falling captured", ext_irq[1], 1);
  endtask

  task automatic t_both();
    do_reset();
    wr(2'd2, 32'h0000_0440);          // pin2 any-transition, enabled
    ext_pin[2] = 1'b1; step(4);
    check("R8 rise", ext_irq[2], 1);
    wr(2'd2, 32'h0000_0444);
    check("R8 cleared", ext_irq[2], 0);
    ext_pin[2] = 1'b0; step(4);
    check("R8 fall", ext_irq[2], 1);
  endtask

  task automatic t_level();
    do_reset();
    wr(2'd2, 32'h0008_8080);          // pin3 level, active high, enabled
    ext_pin[3] = 1'b1;
    step();
    check("R12 not after one edge", ext_irq[3], 0);
    step();
    check("R12 after two edges", ext_irq[3], 1);
    wr(2'd2, 32'h0008_8088);
    check("R9 clear ignored", ext_irq[3], 1);
    ext_pin[3] = 1'b0; step(2);
    check("R9 follows pin", ext_irq[3], 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    do_reset();
    wr(2'd2, 32'h0001_0000);          // pin0 edge, active high, disabled
    ext_pin[0] = 1'b1; step(4);
    check("R10 line gated", ext_irq[0], 0);
    rd(2'd2, d); check("R10 state visible", d[0], 1);
    wr(2'd2, 32'h0001_0010);
    check("R10 enable reveals", ext_irq[0], 1);
  endtask

  task automatic t_prio();
    do_reset();
    src_lvl = 32'h20;
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'h0006_6060);          // pins 1,2 level, active high, enabled
    ext_pin = 4'b0110;
    timer_irq = 1'b1;
    step(3);
    check("R11 timer first", svc_sel, 1);
    timer_irq = 1'b0; #1;
    check("R11 internal next", svc_sel, 2);
    wr(2'd1, 32'h0);
    check("R11 lowest external", {ext_irq, svc_sel}, {4'b0110, 3'd4});
  endtask

  initial begin
    t_reset();
    t_status_mask();
    t_rotate();
    t_edge();
    t_both();
    t_level();
    t_enable();
    t_prio();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule